// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Vector Generation

This block picks a single interrupt from many request lines for a small microcontroller core. The lines are one non-maskable request, two external request pins, and the internal requests of six peripheral modules: three 16-bit timers with four sources each, one 8-bit timer with three sources, a serial port with three sources and an A/D converter with one. Each maskable module (counting each external pin as a module) has a 3-bit level. The levels are held in four 8-bit priority registers that are written and read over a small register bus.

Every clock the block compares all pending requests. It drops those that the global enable or the CPU mask shuts out and chooses a winner by level. Ties are settled first inside a module and then across modules. The winner's level and vector-table entry address are registered. The address is taken from the minimum-mode map (2-byte entries) or the maximum-mode map (4-byte entries). When the CPU raises its acknowledge, the outputs freeze and a one-cycle accept pulse follows. Request lines are level-sensitive and are cleared by their own sources.

Top module: `pic_vector_arbiter`

## Requirements
- R1: After reset every priority field reads 0, and `irq_pending`, `accept`, `vec_addr` and `irq_level` are all 0.
- R2: A write stores `wr_data` in the register that `wr_addr` selects (0 to 3), but bits 7 and 3 always read back 0. In each register, bits 6:4 set the level of the first module and bits 2:0 the level of the second. Register 0 holds IRQ0 and IRQ1, register 1 holds timer 1 and timer 2, register 2 holds timer 3 and the 8-bit timer, and register 3 holds the serial port and the A/D converter. `rd_data` shows the register that `rd_addr` selects, without delay.
- R3: A maskable request takes part only when `int_en` is 1 and its module level is strictly greater than `cpu_mask`. When nothing takes part, `irq_pending` is 0, and `vec_addr` and `irq_level` are 0.
- R4: `nmi_req` always wins, with `irq_level` = 8, whatever the values of `int_en`, `cpu_mask` and the other requests.
- R5: Among the maskable requests that take part, the module with the highest level wins.
- R6: When modules share the highest level, the order from highest to lowest is IRQ0, IRQ1, timer 1, timer 2, timer 3, 8-bit timer, serial port, A/D converter.
- R7: Inside a module, the lower request bit index wins. For the 16-bit timers, bits 0 to 3 are capture, compare A, compare B and overflow. For the 8-bit timer, bits 0 to 2 are compare A, compare B and overflow. For the serial port, bits 0 to 2 are receive error, receive full and transmit empty.
- R8: With `max_mode` = 0 the vectors are: NMI 0x16, IRQ0 0x40, IRQ1 0x42, A/D 0x70. Timer 1, timer 2, timer 3, the 8-bit timer and the serial port start at 0x48, 0x50, 0x58, 0x60 and 0x68, plus 2 times the source bit index.
- R9: With `max_mode` = 1 every vector is twice its minimum-mode value (NMI 0x2C, IRQ0 0x80, timer 1 at 0x90 plus 4 times the index, A/D 0xE0).
- R10: The outputs are registered: they show the winner for the inputs sampled at the previous rising edge.
- R11: While `ack` is 1, `irq_pending`, `irq_level` and `vec_addr` hold their values. A rising edge on `ack` with `irq_pending` set gives `accept` = 1 for exactly one cycle, starting at the edge that samples `ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Priority register write strobe |
| wr_addr | input | 2 | Register to write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register to read |
| rd_data | output | 8 | Read data (bits 7 and 3 are zero) |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | 2 | External requests, bit 0 = IRQ0 |
| tmr1_req | input | 4 | Timer 1 sources (capture, cmpA, cmpB, overflow) |
| tmr2_req | input | 4 | Timer 2 sources |
| tmr3_req | input | 4 | Timer 3 sources |
| tmr8_req | input | 3 | 8-bit timer sources (cmpA, cmpB, overflow) |
| ser_req | input | 3 | Serial sources (error, rx full, tx empty) |
| adc_req | input | 1 | A/D conversion done |
| int_en | input | 1 | Global enable for maskable requests |
| cpu_mask | input | 3 | Requests at or below this level are blocked |
| max_mode | input | 1 | 1 selects the 4-byte vector map |
| ack | input | 1 | CPU acknowledge |
| irq_pending | output | 1 | A winner exists |
| vec_addr | output | 8 | Winner's vector-table entry address |
| irq_level | output | 4 | Winner's level (8 for NMI) |
| accept | output | 1 | One-cycle pulse on acknowledge |

## Verification
Sparse random requests, running against randomly rewritten priority registers and random mask, enable and mode settings, are compared with a reference model. This separates selection by level from selection by fixed order. Directed cases set two modules to the same level to expose the cross-module order, and raise several sources of one module to expose the in-module order. One NMI case uses the enable off and the mask at 7, which shows that NMI ignores both. Each check is made in both vector maps, which tells the 2-byte spacing from the 4-byte spacing. An acknowledge sequence changes the requests while `ack` is high, which separates the freeze from the normal update and the single accept pulse from a level-following one.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int LVL_W   = 3;
    localparam int N_MOD   = 8;
    localparam int SUB_N   = 4;
    localparam int VEC_W   = 8;
    localparam int DATA_W  = 8;
    localparam int N_PREG  = N_MOD / 2;
    localparam int OUT_LW  = LVL_W + 1;

    localparam logic [VEC_W-1:0] NMI_MIN_VEC = 8'h16;

    typedef struct packed {
        logic              pending;
        logic [OUT_LW-1:0] level;
        logic [VEC_W-1:0]  vec;
        logic              ack_seen;
        logic              accept;
    } arb_state_t;

    function automatic logic [VEC_W-1:0] mod_min_base(input logic [2:0] m);
        case (m)
            3'd0:    return 8'h40;
            3'd1:    return 8'h42;
            3'd2:    return 8'h48;
            3'd3:    return 8'h50;
            3'd4:    return 8'h58;
            3'd5:    return 8'h60;
            3'd6:    return 8'h68;
            default: return 8'h70;
        endcase
    endfunction
endpackage

// File: rtl/pic_prio_regs.sv
module pic_prio_regs #(
    parameter int N_REG = 4,
    parameter int DW    = 8,
    parameter int LW    = 3,
    localparam int AW   = (N_REG > 1) ? $clog2(N_REG) : 1,
    localparam int HALF = DW / 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [DW-1:0]         wr_data,
    input  logic [AW-1:0]         rd_addr,
    output logic [DW-1:0]         rd_data,
    output logic [2*N_REG*LW-1:0] lvl_flat
);
    localparam logic [DW-1:0] FIELD_MASK =
        DW'(((1 << LW) - 1) << HALF) | DW'((1 << LW) - 1);

    logic [DW-1:0] regs_d [N_REG];
    logic [DW-1:0] regs_q [N_REG];

    always_comb begin
        for (int r = 0; r < N_REG; r++) begin
            regs_d[r] = regs_q[r];
        end
        if (wr_en) begin
            regs_d[wr_addr] = wr_data & FIELD_MASK;
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < N_REG; r++) begin
            if (!rst_n) regs_q[r] <= '0;
            else        regs_q[r] <= regs_d[r];
        end
    end

    assign rd_data = regs_q[rd_addr];

    // Even module index takes the upper field, odd the lower.
    for (genvar g = 0; g < N_REG; g++) begin : g_fields
        assign lvl_flat[(2*g)*LW   +: LW] = regs_q[g][HALF +: LW];
        assign lvl_flat[(2*g+1)*LW +: LW] = regs_q[g][0 +: LW];
    end
endmodule

// File: rtl/pic_src_pick.sv
module pic_src_pick #(
    parameter int W   = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pic_vector_arbiter.sv
module pic_vector_arbiter
    import pic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        nmi_req,
    input  logic [1:0]  irq_req,
    input  logic [3:0]  tmr1_req,
    input  logic [3:0]  tmr2_req,
    input  logic [3:0]  tmr3_req,
    input  logic [2:0]  tmr8_req,
    input  logic [2:0]  ser_req,
    input  logic        adc_req,
    input  logic        int_en,
    input  logic [2:0]  cpu_mask,
    input  logic        max_mode,
    input  logic        ack,
    output logic        irq_pending,
    output logic [7:0]  vec_addr,
    output logic [3:0]  irq_level,
    output logic        accept
);
    localparam int SIW = $clog2(SUB_N);
    localparam int MIW = $clog2(N_MOD);

    logic [2*N_PREG*LVL_W-1:0] lvl_flat;
    logic [SUB_N-1:0]          mod_req [N_MOD];
    logic                      mod_any [N_MOD];
    logic [SIW-1:0]            mod_idx [N_MOD];

    pic_prio_regs #(.N_REG(N_PREG), .DW(DATA_W), .LW(LVL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .lvl_flat (lvl_flat)
    );

    // Module order here is the cross-module tie order.
    assign mod_req[0] = {3'b000, irq_req[0]};
    assign mod_req[1] = {3'b000, irq_req[1]};
    assign mod_req[2] = tmr1_req;
    assign mod_req[3] = tmr2_req;
    assign mod_req[4] = tmr3_req;
    assign mod_req[5] = {1'b0, tmr8_req};
    assign mod_req[6] = {1'b0, ser_req};
    assign mod_req[7] = {3'b000, adc_req};

    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        pic_src_pick #(.W(SUB_N)) u_pick (
            .req (mod_req[m]),
            .any (mod_any[m]),
            .idx (mod_idx[m])
        );
    end

    arb_state_t st_d, st_q;
    logic              found;
    logic [LVL_W-1:0]  best_l;
    logic [MIW-1:0]    best_m;
    logic [SIW-1:0]    best_s;
    logic [LVL_W-1:0]  lvl_m;
    logic [VEC_W-1:0]  min_vec;

    always_comb begin
        st_d   = st_q;
        found  = 1'b0;
        best_l = '0;
        best_m = '0;
        best_s = '0;
        lvl_m  = '0;
        for (int m = 0; m < N_MOD; m++) begin
            lvl_m = lvl_flat[m*LVL_W +: LVL_W];
            if (mod_any[m] && int_en && (lvl_m > cpu_mask) &&
                (!found || lvl_m > best_l)) begin
                found  = 1'b1;
                best_l = lvl_m;
                best_m = MIW'(m);
                best_s = mod_idx[m];
            end
        end

        if (nmi_req)    min_vec = NMI_MIN_VEC;
        else if (found) min_vec = mod_min_base(best_m) + {{(VEC_W-SIW-1){1'b0}}, best_s, 1'b0};
        else            min_vec = '0;

        st_d.accept   = ack & ~st_q.ack_seen & st_q.pending;
        st_d.ack_seen = ack;
        if (!ack) begin
            st_d.pending = nmi_req | found;
            st_d.level   = nmi_req ? OUT_LW'(1 << LVL_W) : {1'b0, best_l};
            st_d.vec     = max_mode ? {min_vec[VEC_W-2:0], 1'b0} : min_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_pending = st_q.pending;
    assign vec_addr    = st_q.vec;
    assign irq_level   = st_q.level;
    assign accept      = st_q.accept;
endmodule

// File: rtl/pic_vector_arbiter_chk.sv
module pic_vector_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rd_data,
    input logic       nmi_req,
    input logic       int_en,
    input logic       max_mode,
    input logic       ack,
    input logic       irq_pending,
    input logic [7:0] vec_addr,
    input logic [3:0] irq_level,
    input logic       accept
);
    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b0 && rd_data[3] == 1'b0);

    // R4
    nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !ack) |=> (irq_pending && irq_level == 4'd8));

    // R3
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nmi_req && !int_en && !ack) |=> (!irq_pending && vec_addr == 8'h00));

    // R9
    max_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (max_mode && !ack) |=> (vec_addr[1:0] == 2'b00));

    // R11
    ack_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ($stable(vec_addr) && $stable(irq_level) && $stable(irq_pending)));

    // R11
    accept_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    // R11
    accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> irq_pending);
endmodule

bind pic_vector_arbiter pic_vector_arbiter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_data     (rd_data),
    .nmi_req     (nmi_req),
    .int_en      (int_en),
    .max_mode    (max_mode),
    .ack         (ack),
    .irq_pending (irq_pending),
    .vec_addr    (vec_addr),
    .irq_level   (irq_level),
    .accept      (accept)
);

// File: tb/pic_vector_arbiter_test.sv
module pic_vector_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       nmi_req = 1'b0;
    logic [1:0] irq_req = '0;
    logic [3:0] tmr1_req = '0, tmr2_req = '0, tmr3_req = '0;
    logic [2:0] tmr8_req = '0, ser_req = '0;
    logic       adc_req = 1'b0;
    logic       int_en = 1'b0;
    logic [2:0] cpu_mask = '0;
    logic       max_mode = 1'b0;
    logic       ack = 1'b0;
    logic       irq_pending;
    logic [7:0] vec_addr;
    logic [3:0] irq_level;
    logic       accept;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] shadow [4];

    always #10 clk = ~clk;

    pic_vector_arbiter uut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
        shadow[a] = d & 8'h77;
    endtask

    task automatic clear_reqs();
        nmi_req = 0; irq_req = 0; tmr1_req = 0; tmr2_req = 0; tmr3_req = 0;
        tmr8_req = 0; ser_req = 0; adc_req = 0;
    endtask

    function automatic logic [3:0] get_req(input int m);
        case (m)
            0: return {3'b0, irq_req[0]};
            1: return {3'b0, irq_req[1]};
            2: return tmr1_req;
            3: return tmr2_req;
            4: return tmr3_req;
            5: return {1'b0, tmr8_req};
            6: return {1'b0, ser_req};
            default: return {3'b0, adc_req};
        endcase
    endfunction

    // Returns {pending, level[3:0], vec[7:0]}
    function automatic logic [12:0] model();
        int bm = -1;
        int bl = 0;
        int bs = 0;
        int v;
        int bases [8] = '{'h40, 'h42, 'h48, 'h50, 'h58, 'h60, 'h68, 'h70};
        if (nmi_req) begin
            v = 'h16 * (max_mode ? 2 : 1);
            return {1'b1, 4'd8, 8'(v)};
        end
        for (int m = 0; m < 8; m++) begin
            logic [3:0] r = get_req(m);
            int l = (m % 2 == 0) ? int'(shadow[m/2][6:4]) : int'(shadow[m/2][2:0]);
            if (r != 0 && int_en && l > int'(cpu_mask) && (bm < 0 || l > bl)) begin
                bm = m; bl = l;
                bs = r[0] ? 0 : r[1] ? 1 : r[2] ? 2 : 3;
            end
        end
        if (bm < 0) return 13'd0;
        v = (bases[bm] + 2 * bs) * (max_mode ? 2 : 1);
        return {1'b1, 4'(bl), 8'(v)};
    endfunction

    task automatic expect_model(input string req);
        logic [12:0] e = model();
        step();
        check(req, int'(irq_pending), int'(e[12]));
        check(req, int'(irq_level), int'(e[11:8]));
        check(req, int'(vec_addr), int'(e[7:0]));
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int r = 0; r < 4; r++) shadow[r] = 8'h00;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1: reset state
        check("R1 pending", int'(irq_pending), 0);
        check("R1 accept", int'(accept), 0);
        check("R1 vec", int'(vec_addr), 0);
        check("R1 level", int'(irq_level), 0);
        for (int r = 0; r < 4; r++) begin
            rd_addr = 2'(r); #1;
            check("R1 prio reg", int'(rd_data), 0);
        end

        // R2: write/read, unused bits zero
        wr(2'd0, 8'hFF); wr(2'd1, 8'hA5); wr(2'd2, 8'h5A); wr(2'd3, 8'h88);
        rd_addr = 2'd0; #1; check("R2 reg0", int'(rd_data), 'h77);
        rd_addr = 2'd1; #1; check("R2 reg1", int'(rd_data), 'h25);
        rd_addr = 2'd2; #1; check("R2 reg2", int'(rd_data), 'h52);
        rd_addr = 2'd3; #1; check("R2 reg3", int'(rd_data), 'h00);

        // R3: levels 0, enabled; nothing may fire
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);
        int_en = 1; cpu_mask = 0;
        irq_req = 2'b11; adc_req = 1;
        step();
        check("R3 level0 blocked", int'(irq_pending), 0);
        // R2 field mapping + R3 mask strictness: ADC (reg3 low) level 3
        wr(2'd3, 8'h03);
        cpu_mask = 3; step(); step();
        check("R3 equal to mask blocked", int'(irq_pending), 0);
        cpu_mask = 2; step(); step();
        check("R3 above mask passes", int'(irq_level), 3);
        check("R2 adc field R8 vec", int'(vec_addr), 'h70);
        int_en = 0; step(); step();
        check("R3 int_en off", int'(irq_pending), 0);
        check("R3 vec zero idle", int'(vec_addr), 0);

        // R4: NMI with everything shut
        cpu_mask = 7; nmi_req = 1;
        step(); step();
        check("R4 nmi level", int'(irq_level), 8);
        check("R8 nmi min vec", int'(vec_addr), 'h16);
        max_mode = 1; step(); step();
        check("R9 nmi max vec", int'(vec_addr), 'h2C);
        max_mode = 0; nmi_req = 0; clear_reqs();

        // R5 / R6: levels and tie order
        int_en = 1; cpu_mask = 0;
        wr(2'd0, 8'h22); wr(2'd1, 8'h25); wr(2'd2, 8'h00); wr(2'd3, 8'h50);
        ser_req = 3'b100; tmr1_req = 4'b1000; adc_req = 1;
        step(); step();
        check("R5 highest level serial", int'(irq_level), 5);
        check("R7 serial tx empty vec", int'(vec_addr), 'h6C);
        ser_req = 0; tmr2_req = 4'b0001;
        step(); step();
        check("R6 tie timer2 over nothing", int'(vec_addr), 'h50);
        irq_req = 2'b10;
        wr(2'd0, 8'h05);
        step(); step();
        check("R6 IRQ1 beats timer2 at same level", int'(vec_addr), 'h42);
        clear_reqs();

        // R7: in-module order, both maps
        tmr3_req = 4'b1110; wr(2'd2, 8'h40);
        step(); step();
        check("R7 timer3 cmpA", int'(vec_addr), 'h5A);
        max_mode = 1; tmr3_req = 4'b1000;
        step(); step();
        check("R9 timer3 ovf max", int'(vec_addr), 'hBC);
        max_mode = 0; clear_reqs();

        // R10: one-cycle latency
        tmr8_req = 3'b010; wr(2'd2, 8'h04);
        check("R10 not yet visible", int'(irq_pending), 0);
        step();
        check("R10 visible after edge", int'(vec_addr), 'h62);

        // R11: freeze + single accept
        ack = 1; tmr8_req = 0; adc_req = 1; wr(2'd3, 8'h07);
        check("R11 accept pulse", int'(accept), 1);
        check("R11 frozen vec", int'(vec_addr), 'h62);
        step();
        check("R11 accept one cycle", int'(accept), 0);
        check("R11 still frozen", int'(vec_addr), 'h62);
        ack = 0; step();
        check("R11 released", int'(vec_addr), 'h70);
        check("R11 no accept after", int'(accept), 0);
        clear_reqs();

        // Random mix, R5 R6 R7 R8 R9
        for (int it = 0; it < 600; it++) begin
            if (it % 25 == 0) wr(2'($urandom_range(3)), 8'($urandom()));
            nmi_req  = ($urandom_range(15) == 0);
            irq_req  = {($urandom_range(3) == 0), ($urandom_range(3) == 0)};
            for (int b = 0; b < 4; b++) begin
                tmr1_req[b] = ($urandom_range(5) == 0);
                tmr2_req[b] = ($urandom_range(5) == 0);
                tmr3_req[b] = ($urandom_range(5) == 0);
            end
            for (int b = 0; b < 3; b++) begin
                tmr8_req[b] = ($urandom_range(5) == 0);
                ser_req[b]  = ($urandom_range(5) == 0);
            end
            adc_req  = ($urandom_range(3) == 0);
            int_en   = ($urandom_range(7) != 0);
            cpu_mask = 3'($urandom_range(4));
            max_mode = 1'($urandom_range(1));
            expect_model("R5 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule